// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block runs one clause-22 management transaction at a time on the MDC clock and the MDIO data line of an Ethernet PHY. Software first writes a clock/preamble word that sets the MDC divider and the preamble option. It then writes one 32-bit command word that holds the whole frame: start bits and opcode, PHY address, register address, turnaround and write data. The write to the command word starts the transaction. The block generates MDC only while a frame is in flight and shifts the frame out MSB first. For a read frame it releases MDIO and samples the PHY's reply.

When a frame ends, a write-one-to-clear event bit rises. For a read frame, the 16 sampled bits then replace the low half of the command/data word, so software reads the result back at the same address it wrote the command to. The register map is word addressed: 0 is the clock/preamble word, 1 is the command/data word, 2 is the event word. Reads of address 3 return zero.

Top module: `mgmt_frame_master`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven, and all three registers read as zero.
- R2: While a frame runs, each MDC high phase and each MDC low phase lasts divider+1 system clocks. When no frame runs, MDC stays low and MDIO is not driven.
- R3: When preamble enable (bit 7 of the clock/preamble word) is 1, 32 one bits precede the start bits. When it is 0, the first MDC rising edge already carries command bit 31.
- R4: The command word is sent MSB first, one bit per MDC period, with exactly 32 (or 64 with preamble) MDC rising edges. MDIO and its enable only change while MDC is low.
- R5: A frame whose top nibble (bits 31:28) is not 0x6 (0x5 = write) drives MDIO for every bit. After the last bit, MDIO is released and MDC returns low.
- R6: A frame whose top nibble is 0x6 (read) releases MDIO for its last 18 bits: command bits 17:16 (turnaround) and bits 15:0.
- R7: After a read frame, bits 15:0 of the command/data word hold the 16 bits sampled on the last 16 MDC rising edges, first sample in bit 15. Bits 31:16 keep the command values.
- R8: Event bit 0 at address 2 sets when a frame ends. Writing 1 to it clears it, and writing 0 leaves it set.
- R9: A command word written while a frame is in progress is ignored: the frame and the final command/data word are those of the first command.
- R10: The event bit reads 1 exactly N·2·(divider+1) clocks after the clock edge that accepts the command, where N is 32 or 64. A divider of 0x1F is supported.
- R11: The clock/preamble word reads back its bits 7:0 (divider in bits 6:0, preamble enable in bit 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0 clock/preamble, 1 command/data, 2 event) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The bench acts as the PHY. It logs MDIO and the enable on every MDC rising edge and drives reply bits after each falling edge, across random dividers, opcodes and preamble settings, plus a 0x1F divider and a zero divider. A design whose preamble count is off, or that adds a spare MDC edge, would show a shifted or over-long bit log. One that releases MDIO at the wrong bit would show the enable pattern moved by one position. If the sampled bits were shifted or reversed, the returned low half would be wrong. A command injected mid-frame would corrupt the log or the data word if it were not ignored. An off-by-one in the divider shows up both in the per-phase clock count and in the completion time.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int CMD_W   = 32;
  localparam int DATA_W  = 16;
  localparam int PRE_LEN = 32;
  localparam int IMG_W   = CMD_W + PRE_LEN;
  localparam int IDX_W   = $clog2(IMG_W) + 1;
  localparam int TA_BITS = 2;

  localparam logic [3:0] NIB_WRITE = 4'h5;
  localparam logic [3:0] NIB_READ  = 4'h6;

  typedef enum logic [1:0] {
    SEL_CLK = 2'd0,
    SEL_CMD = 2'd1,
    SEL_EVT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Index of the final frame bit.
  function automatic logic [IDX_W-1:0] last_bit(input logic pre);
    return pre ? IDX_W'(IMG_W - 1) : IDX_W'(CMD_W - 1);
  endfunction

  // First bit index at which a read frame lets go of the line.
  function automatic logic [IDX_W-1:0] release_idx(input logic pre);
    return last_bit(pre) - IDX_W'(DATA_W + TA_BITS - 1);
  endfunction

  // First bit index whose rising edge carries PHY read data.
  function automatic logic [IDX_W-1:0] sample_idx(input logic pre);
    return last_bit(pre) - IDX_W'(DATA_W - 1);
  endfunction

  function automatic logic nib_is_read(input logic [3:0] nib);
    return nib == NIB_READ;
  endfunction

  // Serial image, left aligned: the MSB goes out first.
  function automatic logic [IMG_W-1:0] frame_image(input logic [CMD_W-1:0] cmd,
                                                   input logic pre);
    return pre ? {{PRE_LEN{1'b1}}, cmd} : {cmd, {PRE_LEN{1'b0}}};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap      = run && (cnt_q == div);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_shifter.sv
module mgmt_shifter
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              pre_en,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              done_read,
  output logic [DATA_W-1:0] rd_word
);
  logic [IMG_W-1:0]  sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              pre_q;
  logic              rd_q;
  logic              busy_q;
  logic [DATA_W-1:0] cap_q;
  logic              at_last;

  assign at_last   = idx_q == last_bit(pre_q);
  assign done      = busy_q && fall_tick && at_last;
  assign done_read = done && rd_q;
  assign busy      = busy_q;
  assign rd_word   = cap_q;
  assign mdio_o    = busy_q && sh_q[IMG_W-1];
  assign mdio_oe   = busy_q && !(rd_q && (idx_q >= release_idx(pre_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      pre_q  <= 1'b0;
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      cap_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        sh_q   <= frame_image(cmd, pre_en);
        idx_q  <= '0;
        pre_q  <= pre_en;
        rd_q   <= nib_is_read(cmd[CMD_W-1 -: 4]);
        cap_q  <= '0;
      end
    end else begin
      if (rise_tick && rd_q && (idx_q >= sample_idx(pre_q)))
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (at_last) begin
          busy_q <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= sh_q << 1;
        end
      end
    end
  end
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CTRL_W = DIV_W + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CMD_W-1:0]  data_q;
  logic              evt_q;

  logic              busy_w;
  logic              done_w;
  logic              done_rd_w;
  logic              rise_w;
  logic              fall_w;
  logic              cmd_wr_w;
  logic              start_w;
  logic              evt_clr_w;
  logic [DATA_W-1:0] rd_word_w;
  logic [DIV_W-1:0]  div_w;
  logic              pre_w;
  reg_sel_e          sel_w;

  assign sel_w     = reg_sel_e'(reg_addr);
  assign div_w     = ctrl_q[DIV_W-1:0];
  assign pre_w     = ctrl_q[DIV_W];
  assign cmd_wr_w  = reg_wr && (sel_w == SEL_CMD);
  assign start_w   = cmd_wr_w && !busy_w;
  assign evt_clr_w = reg_wr && (sel_w == SEL_EVT) && reg_wdata[0];

  mgmt_mdc_gen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_w),
    .div       (div_w),
    .mdc       (mdc),
    .rise_tick (rise_w),
    .fall_tick (fall_w)
  );

  mgmt_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .cmd       (reg_wdata),
    .pre_en    (pre_w),
    .rise_tick (rise_w),
    .fall_tick (fall_w),
    .mdio_i    (mdio_i),
    .busy      (busy_w),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done_w),
    .done_read (done_rd_w),
    .rd_word   (rd_word_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (reg_wr && (sel_w == SEL_CLK))
        ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (start_w)
        data_q <= reg_wdata;
      else if (done_rd_w)
        data_q[DATA_W-1:0] <= rd_word_w;
      if (done_w)
        evt_q <= 1'b1;
      else if (evt_clr_w)
        evt_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel_w)
      SEL_CLK: reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      SEL_CMD: reg_rdata = data_q;
      SEL_EVT: reg_rdata = {31'd0, evt_q};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mgmt_frame_checker.sv
module mgmt_frame_checker #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             done,
  input logic             evt,
  input logic             cmd_wr,
  input logic [31:0]      data,
  input logic [DIV_W-1:0] div
);
  logic [DIV_W:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (mdc) hi_cnt <= hi_cnt + 1'b1;
    else          hi_cnt <= '0;
  end

  // R2: no clock and no drive between frames
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R2: each high phase spans divider+1 clocks
  assert_high_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == {1'b0, div} + 1'b1));

  // R4: line value and enable hold while MDC is high
  assert_mdio_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R5: the line is released once the frame ends
  assert_release_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mdio_oe && !mdc));

  // R8: completion raises the event bit
  assert_event_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> evt);

  // R9: a command written mid-frame leaves the data word alone
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !done) |=> $stable(data));
endmodule

bind mgmt_frame_master mgmt_frame_checker #(.DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .busy    (busy_w),
  .done    (done_w),
  .evt     (evt_q),
  .cmd_wr  (cmd_wr_w),
  .data    (data_q),
  .div     (div_w)
);

// File: tb/sim_mgmt_frame_master.sv
`timescale 1ns/1ps
module sim_mgmt_frame_master;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // PHY model state
  logic [63:0] log_o;
  logic [63:0] log_oe;
  int          k;
  int          dstart;
  logic [15:0] resp;

  mgmt_frame_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  initial forever begin
    @(posedge mdc);
    if (k < 64) begin
      log_o[k]  = mdio_o;
      log_oe[k] = mdio_oe;
    end
    k++;
  end

  initial forever begin
    @(negedge mdc);
    mdio_i = (k >= dstart && k < dstart + 16) ? resp[15 - (k - dstart)] : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    summary();
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic logic exp_bit(input int i, input logic pre, input logic [31:0] c);
    if (pre) return (i < 32) ? 1'b1 : c[63 - i];
    return c[31 - i];
  endfunction

  task automatic txn(input logic [6:0] d, input logic pre, input logic [31:0] cmd,
                     input logic [15:0] rsp, input int inject);
    int n, hi, nb, mism, pmis, oemis;
    bit got, isrd;
    logic [31:0] v, expd;
    wr(2'd0, {24'd0, pre, d});
    rd(2'd0, v);
    chk(v == {24'd0, pre, d}, "R11 clock word readback", v, {24'd0, pre, d});
    wr(2'd2, 32'd1);
    nb     = pre ? 64 : 32;
    isrd   = (cmd[31:28] == 4'h6);
    dstart = isrd ? nb - 16 : 1000;
    resp   = rsp;
    k      = 0;
    mdio_i = 1'b1;
    wr(2'd1, cmd);
    reg_addr = 2'd2;
    n = 0; hi = 0; got = 0;
    while (!got && n < 20000) begin
      @(negedge clk);
      n++;
      if (mdc) hi++;
      if (!reg_wr && reg_addr == 2'd2 && reg_rdata[0]) got = 1;
      else if (n == inject) begin
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = ~cmd;
      end else if (n == inject + 1) begin
        reg_wr = 1'b0; reg_addr = 2'd2;
      end
    end
    chk(n == nb * 2 * (d + 1), "R10 completion time", n, nb * 2 * (d + 1));
    chk(hi == nb * (d + 1), "R2 MDC high clocks", hi, nb * (d + 1));
    repeat (3) @(negedge clk);
    chk(k == nb, "R4 rising edge count", k, nb);
    mism = 0; pmis = 0; oemis = 0;
    for (int i = 0; i < nb; i++) begin
      bit drv;
      drv = !(isrd && i >= nb - 18);
      if (log_oe[i] != drv) oemis++;
      if (drv && log_o[i] != exp_bit(i, pre, cmd)) begin
        if (pre && i < 32) pmis++;
        else mism++;
      end
    end
    if (pre) chk(pmis == 0, "R3 preamble ones", pmis, 0);
    else chk(log_o[0] == cmd[31] && log_o[1] == cmd[30], "R3 no preamble",
             {30'd0, log_o[0], log_o[1]}, {30'd0, cmd[31], cmd[30]});
    chk(mism == 0, "R4 frame bits", mism, 0);
    chk(oemis == 0, isrd ? "R6 read release pattern" : "R5 write drive pattern",
        oemis, 0);
    chk(!mdc && !mdio_oe, "R5 idle after frame", {30'd0, mdc, mdio_oe}, 0);
    rd(2'd1, v);
    expd = isrd ? {cmd[31:16], rsp} : cmd;
    chk(v == expd, inject > 0 ? "R9 mid-frame command ignored" : "R7 data word",
        v, expd);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    mdio_i = 1'b1; k = 0; dstart = 1000; resp = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mdc && !mdio_oe, "R1 pins after reset", {30'd0, mdc, mdio_oe}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 0, "R1 register after reset", v, 0);
    end

    // directed: maximum required divider, preamble, read
    txn(7'h1F, 1'b1, {4'h6, 5'd3, 5'd2, 2'b10, 16'h0000}, 16'hA5C3, 0);
    // directed: zero divider, no preamble, write
    txn(7'd0, 1'b0, {4'h5, 5'd31, 5'd17, 2'b10, 16'hBEEF}, 16'h0, 0);
    // event bit write-one-to-clear
    wr(2'd2, 32'd0);
    rd(2'd2, v);
    chk(v == 32'd1, "R8 write zero keeps event", v, 1);
    wr(2'd2, 32'd1);
    rd(2'd2, v);
    chk(v == 32'd0, "R8 write one clears event", v, 0);
    // directed: command written mid-frame
    txn(7'd2, 1'b0, {4'h6, 5'd1, 5'd1, 2'b10, 16'h1234}, 16'h8001, 9);
    txn(7'd1, 1'b1, {4'h5, 5'd7, 5'd9, 2'b10, 16'h00FF}, 16'h0, 30);

    for (int t = 0; t < 14; t++) begin
      logic [6:0]  d;
      logic        pre;
      logic [3:0]  nib;
      logic [31:0] c;
      d   = 7'($urandom % 6);
      pre = 1'($urandom % 2);
      nib = ($urandom % 2) ? 4'h6 : 4'h5;
      c   = {nib, 5'($urandom), 5'($urandom), 2'b10, 16'($urandom)};
      txn(d, pre, c, 16'($urandom), 0);
    end
    summary();
  end
endmodule